// File: doc/BRIEF.md
# Channel Zero Code Suppressor

This block keeps enough ones on a T1 line by rewriting 8-bit channel bytes under one of several ones-density schemes. A byte arrives with a valid strobe, a flag that marks bytes carried in a signalling frame, and a 3-bit scheme select. One clock later the block presents the rewritten byte with its own valid strobe.

Each rule has its own trigger. Four of the select codes apply a rule. Every other code, including the one used while the line runs B8ZS, passes the byte through unchanged. The block keeps no state from one byte to the next, so one instance can serve the transmit path and another the receive path. Frame alignment and channel counting happen upstream, and they supply the signalling flag.

Top module: `chan_ones_fill`

## Requirements
- R1: While reset is high and on the first sample after it, out_valid is 0 and out_byte is 0x00.
- R2: out_valid equals in_valid delayed by exactly one clock. When in_valid is 0, out_byte keeps its previous value.
- R3: With scheme_sel = 000 (bypass, also used for B8ZS), out_byte equals the input byte.
- R4: With scheme_sel = 001, bit 0 (the LSB) of every byte is forced to 1 and bits 7..1 are kept, whatever the byte's value.
- R5: With scheme_sel = 010, an all-zero byte becomes 0x01 when in_sig is 0 and stays 0x00 when in_sig is 1.
- R6: With scheme_sel = 011, an all-zero byte becomes 0x98 (binary 10011000, bit 7 first).
- R7: With scheme_sel = 100, an all-zero byte becomes 0x02, which sets bit 1.
- R8: With scheme_sel = 010, 011 or 100, a byte with any bit set passes unchanged.
- R9: scheme_sel values 101, 110 and 111 behave as bypass.
- R10: in_sig has no effect on the output for any scheme_sel other than 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Channel byte, bit 0 is the LSB |
| in_sig | input | 1 | Byte belongs to a signalling frame |
| scheme_sel | input | 3 | Ones-density scheme code |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Rewritten channel byte |

## Verification
Every scheme code, including the three unused ones, is given the same set of bytes: all zeros, a lone LSB, a lone MSB, 0xFE and a mixed pattern. Each byte is sent once with the signalling flag low and once with it high. The zero byte shows which fill pattern each scheme applies. The lone-LSB and 0xFE bytes tell the forced-LSB scheme apart from the zero-only schemes. The repeat with the flag set shows that the exception applies only under the LSB-fill zero rule. Back-to-back bytes and idle gaps check the one-cycle strobe latency and that the output holds when no byte arrives.

// File: rtl/zcs_pkg.sv
package zcs_pkg;

    localparam int ZCS_BYTE_W = 8;

    typedef enum logic [2:0] {
        ZS_PASS = 3'd0,
        ZS_JAM  = 3'd1,
        ZS_GTE  = 3'd2,
        ZS_DDS  = 3'd3,
        ZS_BELL = 3'd4
    } zs_mode_e;

    typedef struct packed {
        logic                  valid;
        logic [ZCS_BYTE_W-1:0] data;
    } zs_beat_t;

    localparam logic [ZCS_BYTE_W-1:0] ZS_DDS_FILL  = 8'b1001_1000;
    localparam logic [ZCS_BYTE_W-1:0] ZS_LSB_ONE   = 8'b0000_0001;
    localparam logic [ZCS_BYTE_W-1:0] ZS_BIT1_ONE  = 8'b0000_0010;

    function automatic zs_mode_e zs_decode(input logic [2:0] code);
        case (code)
            3'd1:    return ZS_JAM;
            3'd2:    return ZS_GTE;
            3'd3:    return ZS_DDS;
            3'd4:    return ZS_BELL;
            default: return ZS_PASS;
        endcase
    endfunction

endpackage

// File: rtl/zcs_mode_decode.sv
module zcs_mode_decode
    import zcs_pkg::*;
(
    input  logic [2:0] sel,
    output zs_mode_e   mode
);
    always_comb begin
        mode = zs_decode(sel);
    end
endmodule

// File: rtl/zcs_zero_detect.sv
module zcs_zero_detect #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] data,
    output logic              is_zero
);
    logic [BYTE_W:0] any_one;
    assign any_one[0] = 1'b0;
    for (genvar i = 0; i < BYTE_W; i++) begin : g_or
        assign any_one[i+1] = any_one[i] | data[i];
    end
    assign is_zero = ~any_one[BYTE_W];
endmodule

// File: rtl/zcs_rewrite.sv
module zcs_rewrite
    import zcs_pkg::*;
#(
    parameter int BYTE_W = ZCS_BYTE_W
) (
    input  zs_mode_e          mode,
    input  logic [BYTE_W-1:0] data,
    input  logic              is_zero,
    input  logic              sig,
    output logic [BYTE_W-1:0] result
);
    always_comb begin
        result = data;
        unique case (mode)
            ZS_JAM:  result = data | ZS_LSB_ONE;
            ZS_GTE:  if (is_zero && !sig) result = ZS_LSB_ONE;
            ZS_DDS:  if (is_zero) result = ZS_DDS_FILL;
            ZS_BELL: if (is_zero) result = ZS_BIT1_ONE;
            default: result = data;
        endcase
    end
endmodule

// File: rtl/chan_ones_fill.sv
module chan_ones_fill
    import zcs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [ZCS_BYTE_W-1:0] in_byte,
    input  logic                  in_sig,
    input  logic [2:0]            scheme_sel,
    output logic                  out_valid,
    output logic [ZCS_BYTE_W-1:0] out_byte
);
    zs_mode_e              mode;
    logic                  zero_byte;
    logic [ZCS_BYTE_W-1:0] fixed;
    zs_beat_t              q;

    zcs_mode_decode u_dec (.sel(scheme_sel), .mode(mode));

    zcs_zero_detect #(.BYTE_W(ZCS_BYTE_W)) u_zero (
        .data(in_byte), .is_zero(zero_byte)
    );

    zcs_rewrite #(.BYTE_W(ZCS_BYTE_W)) u_rw (
        .mode(mode), .data(in_byte), .is_zero(zero_byte),
        .sig(in_sig), .result(fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid;
            if (in_valid) q.data <= fixed;
        end
    end

    assign out_valid = q.valid;
    assign out_byte  = q.data;
endmodule

// File: rtl/chan_ones_fill_chk.sv
module chan_ones_fill_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       in_sig,
    input logic [2:0] scheme_sel,
    input logic       out_valid,
    input logic [7:0] out_byte
);
    logic in_sig_seen;
    assign in_sig_seen = in_sig;

    p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_byte));
    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scheme_sel == 3'd0) |=> out_byte == $past(in_byte));
    p_jam_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scheme_sel == 3'd1) |=> (out_byte[0] && out_byte[7:1] == $past(in_byte[7:1])));
    p_gte_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scheme_sel == 3'd2 && in_byte == 8'h00) |=> out_byte == {7'd0, !$past(in_sig_seen)});
    p_dds_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scheme_sel == 3'd3 && in_byte == 8'h00) |=> out_byte == 8'h98);
    p_bell_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scheme_sel == 3'd4 && in_byte == 8'h00) |=> out_byte == 8'h02);
    p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scheme_sel >= 3'd2 && scheme_sel <= 3'd4 && in_byte != 8'h00) |=> out_byte == $past(in_byte));
    p_spare_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scheme_sel >= 3'd5) |=> out_byte == $past(in_byte));
endmodule

bind chan_ones_fill chan_ones_fill_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_sig(in_sig), .scheme_sel(scheme_sel),
    .out_valid(out_valid), .out_byte(out_byte)
);

// File: tb/sim_chan_ones_fill.sv
`timescale 1ns/1ps
module sim_chan_ones_fill;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_sig = 1'b0;
    logic [2:0] scheme_sel = 3'd0;
    logic       out_valid;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] last_exp = 8'h00;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    chan_ones_fill u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_sig(in_sig), .scheme_sel(scheme_sel),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    function automatic logic [7:0] expect_byte(logic [7:0] b, logic s, logic [2:0] m);
        case (m)
            3'd1:    return {b[7:1], 1'b1};
            3'd2:    return (b == 8'h00) ? (s ? 8'h00 : 8'h01) : b;
            3'd3:    return (b == 8'h00) ? 8'h98 : b;
            3'd4:    return (b == 8'h00) ? 8'h02 : b;
            default: return b;
        endcase
    endfunction

    function automatic string pick_tag(logic [7:0] b, logic s, logic [2:0] m);
        if (m >= 3'd5) return "R9";
        if (s && m != 3'd2) return "R10";
        if (m == 3'd0) return "R3";
        if (m == 3'd1) return "R4";
        if (b != 8'h00) return "R8";
        if (m == 3'd2) return "R5";
        if (m == 3'd3) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b, logic s, logic [2:0] m);
        @(posedge clk); #1;
        in_valid = 1'b1; in_byte = b; in_sig = s; scheme_sel = m;
        exp_q.push_back(expect_byte(b, s, m));
        tag_q.push_back(pick_tag(b, s, m));
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; in_byte = 8'hA5; in_sig = 1'b1; scheme_sel = 3'd3;
    endtask

    // monitor: pops expected bytes as outputs appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2", 8'h01, 8'h00);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, out_byte, e);
                last_exp = e;
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] pats [5] = '{8'h00, 8'h01, 8'h80, 8'hFE, 8'h5A};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {7'd0, out_valid}, 8'h00);
        check("R1", out_byte, 8'h00);
        #1; rst = 1'b0;
        @(negedge clk);
        check("R1", {7'd0, out_valid}, 8'h00);
        check("R1", out_byte, 8'h00);

        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 5; p++) begin
                    send(pats[p], s[0], m[2:0]);
                end
                idle();
                @(negedge clk);
                // R2: one cycle after idle input, the last byte is out; next cycle strobe low and byte held
                @(negedge clk);
                check("R2", {7'd0, out_valid}, 8'h00);
                check("R2", out_byte, last_exp);
            end
        end

        // R2: a long idle gap with toggling data keeps the output still
        repeat (4) begin
            @(posedge clk); #1; in_byte = ~in_byte; scheme_sel = scheme_sel + 3'd1;
        end
        @(negedge clk);
        check("R2", out_byte, last_exp);
        check("R2", {7'd0, out_valid}, 8'h00);

        // R6 and R7 with a single isolated byte each
        send(8'h00, 1'b0, 3'd3); idle();
        send(8'h00, 1'b1, 3'd4); idle();
        repeat (3) @(negedge clk);
        check("R2", exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule